// File: doc/BRIEF.md
# Boot ROM Region Decoder

This block watches the memory cycles a host presents and claims those whose address lies in one of two boot ROM windows. One window sits just below the 1 MB line and the other at the top of the 32-bit space. For each cycle it claims, it raises a one-clock claim pulse. It also drives the active-low strobes of a narrow-bus memory cycle: ROM chip select, memory read, memory write and a generic write strobe. It reports whether the cycle should run 8 or 16 bits wide.

Out of reset, the low window is 64 KB and the high window is 256 KB. Two configuration inputs each enlarge one window. Writes into a window normally leave the ROM chip select deasserted. A flash-write enable lets the chip select take part in a write, so that flash parts can be programmed. The narrow-bus timing engine and data steering lie downstream. This block stops at the claim-and-strobe decision and holds the strobes for a fixed, parameterised number of clocks.

Top module: `boot_rom_decoder`

## Requirements
- R1: While `rst` is high and on the first clock after it, `claim_o` is 0, all four strobes are 1 (deasserted), and `width16_o` equals `strap_wide_i` as sampled during reset.
- R2: With both enlarge bits clear, a valid cycle to 0x000F0000..0x000FFFFF or to 0xFFFC0000..0xFFFFFFFF is claimed. 0x000EFFFF and 0xFFFBFFFF are not claimed.
- R3: With `cfg_big_high_i` = 1, the high window spans 0xFF000000..0xFFFFFFFF. 0xFEFFFFFF stays unclaimed.
- R4: With `cfg_big_low_i` = 1, the low window spans 0x000E0000..0x000FFFFF. 0x000DFFFF stays unclaimed.
- R5: A claimed read (`cyc_write_i` = 0) registered on clock edge k gives `claim_o` = 1 for the single cycle after edge k. From edge k, `rom_cs_n_o` and `mem_rd_n_o` are 0, and `mem_wr_n_o` and `wr_n_o` stay 1.
- R6: A claimed write with `cfg_rom_wr_en_i` = 0 drives `mem_wr_n_o` and `wr_n_o` to 0. `rom_cs_n_o` and `mem_rd_n_o` stay 1.
- R7: A claimed write with `cfg_rom_wr_en_i` = 1 drives `rom_cs_n_o`, `mem_wr_n_o` and `wr_n_o` to 0. `mem_rd_n_o` stays 1.
- R8: Asserted strobes stay low for exactly STROBE_CYCLES clocks and are all released on the same edge.
- R9: A valid cycle is ignored, with no claim and no strobe change, if it is presented on any clock where strobes are held or on the clock on which they are released.
- R10: An internal width register loads `strap_wide_i` during reset and takes `width_wr_data_i` when `width_wr_i` is 1 (1 = 16-bit, 0 = 8-bit). `width16_o` takes the register value on each claim edge, using the value from before any write on that same edge.
- R11: A valid cycle outside every enabled window produces no claim and leaves all strobes at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| strap_wide_i | input | 1 | Width strap, sampled while in reset (1 = 16-bit) |
| cyc_valid_i | input | 1 | Host memory cycle valid this clock |
| cyc_write_i | input | 1 | 1 = write, 0 = read |
| cyc_addr_i | input | ADDR_W | Host memory address |
| cfg_big_high_i | input | 1 | Enlarge the high window to 16 MB |
| cfg_big_low_i | input | 1 | Enlarge the low window to 128 KB |
| cfg_rom_wr_en_i | input | 1 | Allow the ROM chip select on writes |
| width_wr_i | input | 1 | Write strobe for the width register |
| width_wr_data_i | input | 1 | New width value (1 = 16-bit) |
| claim_o | output | 1 | One-clock pulse on a claimed cycle |
| rom_cs_n_o | output | 1 | ROM chip select, active low |
| mem_rd_n_o | output | 1 | Memory read strobe, active low |
| mem_wr_n_o | output | 1 | Memory write strobe, active low |
| wr_n_o | output | 1 | Generic write strobe, active low |
| width16_o | output | 1 | Width of the current claimed cycle (1 = 16-bit) |

## Verification
The bench builds the block with STROBE_CYCLES = 3 and keeps the 32-bit address and default window bases. The short hold lets many claims, back-to-back valid cycles and release-edge collisions fit in a brief run. Each window edge is probed one byte inside and one byte outside, with the enlarge bits both clear and set. A width write is issued both on an idle clock and on the same edge as a claim, to expose which value the claim captures.

// File: rtl/bootrom_pkg.sv
package bootrom_pkg;

  typedef enum logic [1:0] {
    KIND_READ     = 2'd0,
    KIND_FLASH_WR = 2'd1,
    KIND_PLAIN_WR = 2'd2
  } rom_kind_e;

  typedef struct packed {
    logic cs_n;
    logic rd_n;
    logic mwr_n;
    logic wr_n;
  } rom_strobe_t;

  localparam rom_strobe_t STROBE_IDLE = '{cs_n: 1'b1, rd_n: 1'b1, mwr_n: 1'b1, wr_n: 1'b1};

  function automatic rom_strobe_t strobe_for(rom_kind_e kind);
    rom_strobe_t s;
    s = STROBE_IDLE;
    case (kind)
      KIND_READ: begin
        s.cs_n = 1'b0;
        s.rd_n = 1'b0;
      end
      KIND_FLASH_WR: begin
        s.cs_n  = 1'b0;
        s.mwr_n = 1'b0;
        s.wr_n  = 1'b0;
      end
      KIND_PLAIN_WR: begin
        s.mwr_n = 1'b0;
        s.wr_n  = 1'b0;
      end
      default: s = STROBE_IDLE;
    endcase
    return s;
  endfunction

endpackage

// File: rtl/bootrom_window.sv
module bootrom_window #(
  parameter int unsigned       ADDR_W   = 32,
  parameter logic [ADDR_W-1:0] BASE     = '0,
  parameter logic [ADDR_W-1:0] BIG_BASE = '0,
  parameter logic [ADDR_W-1:0] LIMIT    = '1
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              big_i,
  output logic              hit_o
);

  logic [ADDR_W-1:0] lower;

  always_comb begin
    lower = big_i ? BIG_BASE : BASE;
    hit_o = (addr_i >= lower) && (addr_i <= LIMIT);
  end

endmodule

// File: rtl/bootrom_width_reg.sv
module bootrom_width_reg (
  input  logic clk,
  input  logic rst,
  input  logic strap_i,
  input  logic wr_i,
  input  logic wdata_i,
  input  logic load_i,
  output logic cyc_width_o
);

  logic width_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      width_q     <= strap_i;
      cyc_width_o <= strap_i;
    end else begin
      if (load_i) cyc_width_o <= width_q;
      if (wr_i)   width_q     <= wdata_i;
    end
  end

endmodule

// File: rtl/bootrom_strobe_gen.sv
module bootrom_strobe_gen
  import bootrom_pkg::*;
#(
  parameter int unsigned STROBE_CYCLES = 4
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        start_i,
  input  rom_kind_e   kind_i,
  output logic        busy_o,
  output logic        claim_o,
  output rom_strobe_t strobe_o
);

  localparam int unsigned CNT_W = $clog2(STROBE_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(STROBE_CYCLES);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q;

  assign busy_o = (cnt_q != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q    <= '0;
      claim_o  <= 1'b0;
      strobe_o <= STROBE_IDLE;
    end else begin
      claim_o <= 1'b0;
      if (busy_o) begin
        if (cnt_q == CNT_LAST) strobe_o <= STROBE_IDLE;
        cnt_q <= cnt_q - CNT_LAST;
      end else if (start_i) begin
        cnt_q    <= CNT_LOAD;
        claim_o  <= 1'b1;
        strobe_o <= strobe_for(kind_i);
      end
    end
  end

endmodule

// File: rtl/boot_rom_decoder.sv
module boot_rom_decoder
  import bootrom_pkg::*;
#(
  parameter int unsigned       ADDR_W        = 32,
  parameter int unsigned       STROBE_CYCLES = 4,
  parameter logic [ADDR_W-1:0] LOW_BASE      = ADDR_W'(32'h000F_0000),
  parameter logic [ADDR_W-1:0] LOW_BIG_BASE  = ADDR_W'(32'h000E_0000),
  parameter logic [ADDR_W-1:0] LOW_LIMIT     = ADDR_W'(32'h000F_FFFF),
  parameter logic [ADDR_W-1:0] HIGH_BASE     = ADDR_W'(32'hFFFC_0000),
  parameter logic [ADDR_W-1:0] HIGH_BIG_BASE = ADDR_W'(32'hFF00_0000),
  parameter logic [ADDR_W-1:0] HIGH_LIMIT    = ADDR_W'(32'hFFFF_FFFF)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              strap_wide_i,
  input  logic              cyc_valid_i,
  input  logic              cyc_write_i,
  input  logic [ADDR_W-1:0] cyc_addr_i,
  input  logic              cfg_big_high_i,
  input  logic              cfg_big_low_i,
  input  logic              cfg_rom_wr_en_i,
  input  logic              width_wr_i,
  input  logic              width_wr_data_i,
  output logic              claim_o,
  output logic              rom_cs_n_o,
  output logic              mem_rd_n_o,
  output logic              mem_wr_n_o,
  output logic              wr_n_o,
  output logic              width16_o
);

  localparam int unsigned NUM_WIN = 2;

  logic [NUM_WIN-1:0] win_hit;
  logic [NUM_WIN-1:0] win_big;
  logic               any_hit;
  logic               busy;
  logic               start;
  rom_kind_e          kind;
  rom_strobe_t        strobe;

  assign win_big = {cfg_big_high_i, cfg_big_low_i};

  for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
    localparam logic [ADDR_W-1:0] W_BASE  = (w == 0) ? LOW_BASE     : HIGH_BASE;
    localparam logic [ADDR_W-1:0] W_BIG   = (w == 0) ? LOW_BIG_BASE : HIGH_BIG_BASE;
    localparam logic [ADDR_W-1:0] W_LIMIT = (w == 0) ? LOW_LIMIT    : HIGH_LIMIT;
    bootrom_window #(
      .ADDR_W  (ADDR_W),
      .BASE    (W_BASE),
      .BIG_BASE(W_BIG),
      .LIMIT   (W_LIMIT)
    ) u_win (
      .addr_i(cyc_addr_i),
      .big_i (win_big[w]),
      .hit_o (win_hit[w])
    );
  end

  always_comb begin
    any_hit = |win_hit;
    start   = cyc_valid_i && any_hit && !busy;
    if (!cyc_write_i)         kind = KIND_READ;
    else if (cfg_rom_wr_en_i) kind = KIND_FLASH_WR;
    else                      kind = KIND_PLAIN_WR;
  end

  bootrom_strobe_gen #(
    .STROBE_CYCLES(STROBE_CYCLES)
  ) u_strobe (
    .clk     (clk),
    .rst     (rst),
    .start_i (start),
    .kind_i  (kind),
    .busy_o  (busy),
    .claim_o (claim_o),
    .strobe_o(strobe)
  );

  bootrom_width_reg u_width (
    .clk        (clk),
    .rst        (rst),
    .strap_i    (strap_wide_i),
    .wr_i       (width_wr_i),
    .wdata_i    (width_wr_data_i),
    .load_i     (start),
    .cyc_width_o(width16_o)
  );

  assign rom_cs_n_o = strobe.cs_n;
  assign mem_rd_n_o = strobe.rd_n;
  assign mem_wr_n_o = strobe.mwr_n;
  assign wr_n_o     = strobe.wr_n;

endmodule

// File: rtl/bootrom_decoder_chk.sv
module bootrom_decoder_chk #(
  parameter int unsigned STROBE_CYCLES = 4
) (
  input logic clk,
  input logic rst,
  input logic cyc_valid_i,
  input logic cfg_rom_wr_en_i,
  input logic claim_o,
  input logic rom_cs_n_o,
  input logic mem_rd_n_o,
  input logic mem_wr_n_o,
  input logic wr_n_o
);

  logic        act;
  logic [15:0] held_q;

  assign act = !mem_rd_n_o || !mem_wr_n_o;

  always_ff @(posedge clk) begin
    if (rst)      held_q <= '0;
    else if (act) held_q <= held_q + 16'd1;
    else          held_q <= '0;
  end

  // R5: a claim only follows a valid host cycle
  a_r5_claim_needs_valid: assert property (@(posedge clk) disable iff (rst)
    claim_o |-> $past(cyc_valid_i));

  // R5: a read keeps both write strobes released
  a_r5_read_no_write: assert property (@(posedge clk) disable iff (rst)
    !mem_rd_n_o |-> (mem_wr_n_o && wr_n_o));

  // R7: chip select on a write only with flash-write enable set
  a_r7_cs_write_needs_en: assert property (@(posedge clk) disable iff (rst)
    ($fell(mem_wr_n_o) && !rom_cs_n_o) |-> $past(cfg_rom_wr_en_i));

  // R8: the write strobes and chip select are released together
  a_r8_release_together: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_wr_n_o) |-> (wr_n_o && rom_cs_n_o));

  // R8: the strobe hold lasts exactly STROBE_CYCLES clocks
  a_r8_fixed_len: assert property (@(posedge clk) disable iff (rst)
    (!act && $past(act)) |-> (held_q == 16'(STROBE_CYCLES)));

  // R9: a claim is a single-cycle pulse
  a_r9_claim_pulse: assert property (@(posedge clk) disable iff (rst)
    claim_o |=> !claim_o);

  // R5: every claim comes with a strobe asserted
  a_r5_claim_strobes: assert property (@(posedge clk) disable iff (rst)
    claim_o |-> act);

endmodule

bind boot_rom_decoder bootrom_decoder_chk #(
  .STROBE_CYCLES(STROBE_CYCLES)
) u_chk (
  .clk            (clk),
  .rst            (rst),
  .cyc_valid_i    (cyc_valid_i),
  .cfg_rom_wr_en_i(cfg_rom_wr_en_i),
  .claim_o        (claim_o),
  .rom_cs_n_o     (rom_cs_n_o),
  .mem_rd_n_o     (mem_rd_n_o),
  .mem_wr_n_o     (mem_wr_n_o),
  .wr_n_o         (wr_n_o)
);

// File: tb/boot_rom_decoder_tb.sv
module boot_rom_decoder_tb;

  localparam int CLK_PERIOD = 10;
  localparam int NCYC       = 3;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        strap = 1'b0;
  logic        valid = 1'b0;
  logic        write = 1'b0;
  logic [31:0] addr = '0;
  logic        big_high = 1'b0;
  logic        big_low = 1'b0;
  logic        wr_en = 1'b0;
  logic        wwr = 1'b0;
  logic        wdata = 1'b0;
  logic        claim, cs_n, rd_n, mwr_n, wr_n, w16;

  int    n_checks = 0;
  int    n_fail   = 0;
  bit    done     = 1'b0;
  string cur_req  = "R1";

  // behavioural reference state
  int m_left = 0;
  bit m_claim = 0, m_cs = 1, m_rd = 1, m_mwr = 1, m_wr = 1, m_reg = 0, m_w16 = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  boot_rom_decoder #(.STROBE_CYCLES(NCYC)) u_dut (
    .clk(clk), .rst(rst), .strap_wide_i(strap), .cyc_valid_i(valid),
    .cyc_write_i(write), .cyc_addr_i(addr), .cfg_big_high_i(big_high),
    .cfg_big_low_i(big_low), .cfg_rom_wr_en_i(wr_en), .width_wr_i(wwr),
    .width_wr_data_i(wdata), .claim_o(claim), .rom_cs_n_o(cs_n),
    .mem_rd_n_o(rd_n), .mem_wr_n_o(mwr_n), .wr_n_o(wr_n), .width16_o(w16)
  );

  function automatic bit in_rom(logic [31:0] a, bit bl, bit bh);
    bit lo, hi;
    lo = (a >= (bl ? 32'h000E0000 : 32'h000F0000)) && (a <= 32'h000FFFFF);
    hi = (a >= (bh ? 32'hFF000000 : 32'hFFFC0000));
    return lo || hi;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_left = 0; m_claim = 0;
      m_cs = 1; m_rd = 1; m_mwr = 1; m_wr = 1;
      m_reg = strap; m_w16 = strap;
    end else begin
      m_claim = 0;
      if (m_left > 0) begin
        m_left--;
        if (m_left == 0) begin m_cs = 1; m_rd = 1; m_mwr = 1; m_wr = 1; end
      end else if (valid && in_rom(addr, big_low, big_high)) begin
        m_claim = 1; m_left = NCYC; m_w16 = m_reg;
        if (!write) begin m_cs = 0; m_rd = 0; end
        else begin m_mwr = 0; m_wr = 0; m_cs = !wr_en; end
      end
      if (wwr) m_reg = wdata;
    end
  end

  task automatic check(string req, string what, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic compare_all();
    check(cur_req, "claim", claim, m_claim);
    check(cur_req, "rom_cs_n", cs_n, m_cs);
    check(cur_req, "mem_rd_n", rd_n, m_rd);
    check(cur_req, "mem_wr_n", mwr_n, m_mwr);
    check(cur_req, "wr_n", wr_n, m_wr);
    check(cur_req, "width16", w16, m_w16);
  endtask

  task automatic tick();
    @(negedge clk);
    compare_all();
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      tick();
      valid = 0; wwr = 0;
    end
  endtask

  task automatic issue(logic [31:0] a, bit w, string req);
    cur_req = req;
    tick();
    valid = 1; write = w; addr = a;
    tick();
    valid = 0;
    idle(NCYC + 2);
  endtask

  task automatic do_reset(bit s);
    tick();
    rst = 1; strap = s; valid = 0; wwr = 0;
    idle(2);
    rst = 0;
  endtask

  initial begin
    cur_req = "R1";
    do_reset(1'b0);
    @(negedge clk);
    // R1 explicit reset state
    check("R1", "claim after reset", claim, 0);
    check("R1", "cs_n after reset", cs_n, 1);
    check("R1", "rd_n after reset", rd_n, 1);
    check("R1", "width16 after reset", w16, 0);

    issue(32'h000F0000, 0, "R2");
    issue(32'h000FFFFF, 0, "R2");
    issue(32'hFFFC0000, 0, "R2");
    issue(32'hFFFFFFFF, 0, "R5");
    issue(32'h000EFFFF, 0, "R2");
    issue(32'hFFFBFFFF, 0, "R2");
    issue(32'h00000000, 0, "R11");
    issue(32'h80000000, 0, "R11");
    issue(32'h00100000, 1, "R11");

    big_high = 1;
    issue(32'hFF000000, 0, "R3");
    issue(32'hFEFFFFFF, 0, "R3");
    big_high = 0;
    issue(32'hFF000000, 0, "R3");

    big_low = 1;
    issue(32'h000E0000, 0, "R4");
    issue(32'h000DFFFF, 0, "R4");
    big_low = 0;
    issue(32'h000E0000, 0, "R4");

    wr_en = 0;
    issue(32'hFFFE0000, 1, "R6");
    issue(32'h000F8000, 1, "R6");
    wr_en = 1;
    issue(32'hFFFE0000, 1, "R7");
    issue(32'h000F8000, 1, "R7");
    wr_en = 0;

    // R8 / R9: valid held for many clocks, collisions with hold and release
    cur_req = "R9";
    tick();
    valid = 1; write = 0; addr = 32'hFFFFFFF0;
    idle(0);
    for (int i = 0; i < 3 * NCYC + 4; i++) begin
      tick();
      valid = 1;
    end
    tick();
    valid = 0;
    idle(NCYC + 2);

    // R10: idle write, then claim
    cur_req = "R10";
    tick();
    wwr = 1; wdata = 1;
    tick();
    wwr = 0;
    issue(32'hFFFF0000, 0, "R10");
    check("R10", "width16 after idle write", w16, 1);
    // R10: write on claim edge takes effect only from next claim
    cur_req = "R10";
    tick();
    valid = 1; write = 0; addr = 32'hFFFF0004; wwr = 1; wdata = 0;
    tick();
    valid = 0; wwr = 0;
    check("R10", "width16 keeps old value on same-edge write", w16, 1);
    idle(NCYC + 2);
    issue(32'hFFFF0008, 0, "R10");
    check("R10", "width16 from next claim", w16, 0);

    // R1 / R10 reset with strap high
    cur_req = "R1";
    do_reset(1'b1);
    @(negedge clk);
    check("R1", "width16 follows strap", w16, 1);
    issue(32'h000F0010, 0, "R10");
    check("R10", "claim width from strap", w16, 1);

    done = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

endmodule